// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit works out the target address of an instruction operand for the non-indexed addressing modes of an 8-bit processor with a 16-bit address space. A sequencer pulses `start_i` with the mode, the program counter that points at the first operand byte, and the page register. The unit then requests operand bytes one at a time over a byte-wide fetch port, where the address comes from the unit and a valid strobe comes back from memory.

When the last byte arrives, the unit presents the effective address, the advanced program counter and the number of bytes consumed, with a one-cycle `done_o` pulse. A page-relative mode joins the page register and one byte. An absolute mode takes a two-byte word, high byte first. The two branch modes add a signed 8-bit or a 16-bit displacement to the program counter that has already moved past the displacement. A new request may be accepted in the cycle in which the previous result is announced.

Top module: `eag_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done_o` and `fetch_req_o` are 0, and `ea_o`, `pc_next_o` and `nbytes_o` are 0.
- R2: Mode 2'b00 (page): `ea_o` = {`dp_i`, first byte}, `nbytes_o` = 1.
- R3: Mode 2'b01 (absolute): `ea_o` = {first byte, second byte}, with the first fetched byte as the high half, and `nbytes_o` = 2.
- R4: Mode 2'b10 (short branch): `ea_o` = `pc_next_o` + the first byte sign-extended from bit 7, modulo 2^16, and `nbytes_o` = 1.
- R5: Mode 2'b11 (long branch): `ea_o` = `pc_next_o` + {first byte, second byte}, modulo 2^16, and `nbytes_o` = 2.
- R6: Byte i of a request (counting from 0) is fetched from address `pc_i` + i modulo 2^16, and `pc_next_o` = `pc_i` + `nbytes_o` modulo 2^16.
- R7: `fetch_req_o` rises in the cycle after a start is accepted and stays high, with `fetch_addr_o` unchanged, until a byte is taken. A byte is taken only in a cycle where `fetch_req_o` and `fetch_vld_i` are both high. `fetch_vld_i` has no effect while `fetch_req_o` is low.
- R8: `done_o` is high for exactly one cycle. That cycle is the one after the last byte is taken, and `fetch_req_o` is low in it. `ea_o`, `pc_next_o` and `nbytes_o` change only together with a `done_o` pulse.
- R9: A start pulse while `fetch_req_o` is high is ignored. The running request completes with its own values, and no extra result follows.
- R10: A start pulse in the `done_o` cycle is accepted, and `fetch_req_o` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a request (accepted when idle) |
| mode_i | input | 2 | Addressing mode, encodings in R2 to R5 |
| pc_i | input | 16 | Address of the first operand byte |
| dp_i | input | 8 | Page register value |
| fetch_req_o | output | 1 | Byte request to memory |
| fetch_addr_o | output | 16 | Address of the requested byte |
| fetch_vld_i | input | 1 | Requested byte is present |
| fetch_data_i | input | 8 | Returned byte |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 16 | Effective address |
| pc_next_o | output | 16 | Program counter past the operand |
| nbytes_o | output | 2 | Operand bytes consumed |

## Verification
Two events can share one cycle: the result strobe of one request and the acceptance of the next start. The bench drives a new start on the same falling edge at which it first sees `done_o`. It then judges two things: the previous result must still match its scoreboard entry, and `fetch_req_o` must be high one cycle later. Requests are run with three memory-latency patterns, with stray valid strobes while idle, and with a start pulse while busy. Together these show that byte acceptance depends only on the request/valid overlap.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    AM_PAGE      = 2'b00,
    AM_ABSOLUTE  = 2'b01,
    AM_BR_SHORT  = 2'b10,
    AM_BR_LONG   = 2'b11
  } amode_e;

  localparam int unsigned CNT_W = 2;

  function automatic logic [CNT_W-1:0] operand_len(input amode_e m);
    return (m == AM_ABSOLUTE || m == AM_BR_LONG) ? CNT_W'(2) : CNT_W'(1);
  endfunction

endpackage

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] dp_i,
  input  logic              fetch_vld_i,
  input  logic [BYTE_W-1:0] fetch_data_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              last_o,
  output amode_e            mode_o,
  output logic [BYTE_W-1:0] dp_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic [ADDR_W-1:0] pc_after_o,
  output logic [CNT_W-1:0]  need_o
);

  logic              busy_q;
  amode_e            mode_q;
  logic [BYTE_W-1:0] dp_q;
  logic [BYTE_W-1:0] hi_q;
  logic [ADDR_W-1:0] pc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;
  logic [CNT_W-1:0]  need;

  assign need  = operand_len(mode_q);
  assign take  = busy_q && fetch_vld_i;
  assign last_o = take && (cnt_q == need - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      mode_q <= AM_PAGE;
      dp_q   <= '0;
      hi_q   <= '0;
      pc_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        mode_q <= amode_e'(mode_i);
        dp_q   <= dp_i;
        pc_q   <= pc_i;
        cnt_q  <= '0;
      end
    end else if (take) begin
      pc_q  <= pc_q + ADDR_W'(1);
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == '0) hi_q <= fetch_data_i;
      if (last_o) busy_q <= 1'b0;
    end
  end

  assign fetch_req_o  = busy_q;
  assign fetch_addr_o = pc_q;
  assign mode_o       = mode_q;
  assign dp_o         = dp_q;
  assign hi_o         = hi_q;
  assign pc_after_o   = pc_q + ADDR_W'(1);
  assign need_o       = need;

endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  amode_e            mode_i,
  input  logic [BYTE_W-1:0] dp_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] pc_after_i,
  output logic [ADDR_W-1:0] ea_o
);

  logic [ADDR_W-1:0] disp;

  // Displacement: sign-extended single byte or the full word.
  always_comb begin
    if (mode_i == AM_BR_SHORT) disp = {{BYTE_W{lo_i[BYTE_W-1]}}, lo_i};
    else                       disp = {hi_i, lo_i};
  end

  always_comb begin
    unique case (mode_i)
      AM_PAGE:     ea_o = {dp_i, lo_i};
      AM_ABSOLUTE: ea_o = {hi_i, lo_i};
      default:     ea_o = pc_after_i + disp;
    endcase
  end

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] dp_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_vld_i,
  input  logic [BYTE_W-1:0] fetch_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic [CNT_W-1:0]  nbytes_o
);

  logic              last;
  amode_e            mode_q;
  logic [BYTE_W-1:0] dp_q;
  logic [BYTE_W-1:0] hi_q;
  logic [ADDR_W-1:0] pc_after;
  logic [CNT_W-1:0]  need;
  logic [ADDR_W-1:0] ea_c;

  eag_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .pc_i         (pc_i),
    .dp_i         (dp_i),
    .fetch_vld_i  (fetch_vld_i),
    .fetch_data_i (fetch_data_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .last_o       (last),
    .mode_o       (mode_q),
    .dp_o         (dp_q),
    .hi_o         (hi_q),
    .pc_after_o   (pc_after),
    .need_o       (need)
  );

  eag_calc #(.BYTE_W(BYTE_W)) u_calc (
    .mode_i     (mode_q),
    .dp_i       (dp_q),
    .hi_i       (hi_q),
    .lo_i       (fetch_data_i),
    .pc_after_i (pc_after),
    .ea_o       (ea_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      ea_o      <= '0;
      pc_next_o <= '0;
      nbytes_o  <= '0;
    end else begin
      done_o <= last;
      if (last) begin
        ea_o      <= ea_c;
        pc_next_o <= pc_after;
        nbytes_o  <= need;
      end
    end
  end

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req_o,
  input logic              fetch_vld_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic [ADDR_W-1:0] pc_next_o,
  input logic [1:0]        nbytes_o
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_req_o) |-> done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !fetch_req_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(ea_o) && $stable(pc_next_o) && $stable(nbytes_o)));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && !fetch_vld_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && fetch_vld_i) |=>
      (!fetch_req_o || fetch_addr_o == ADDR_W'($past(fetch_addr_o) + ADDR_W'(1))));

  // R2
  nbytes_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (nbytes_o == 2'd1 || nbytes_o == 2'd2));

endmodule

bind eag_top eag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fetch_req_o  (fetch_req_o),
  .fetch_vld_i  (fetch_vld_i),
  .fetch_addr_o (fetch_addr_o),
  .done_o       (done_o),
  .ea_o         (ea_o),
  .pc_next_o    (pc_next_o),
  .nbytes_o     (nbytes_o)
);

// File: tb/sim_eag_top.sv
module sim_eag_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  dp_i = '0;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic        fetch_vld_i = 1'b0;
  logic [7:0]  fetch_data_i = '0;
  logic        done_o;
  logic [15:0] ea_o;
  logic [15:0] pc_next_o;
  logic [1:0]  nbytes_o;

  always #10 clk = ~clk;

  eag_top u0 (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .pc_i         (pc_i),
    .dp_i         (dp_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_vld_i  (fetch_vld_i),
    .fetch_data_i (fetch_data_i),
    .done_o       (done_o),
    .ea_o         (ea_o),
    .pc_next_o    (pc_next_o),
    .nbytes_o     (nbytes_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] ea;
    logic [15:0] pc;
    logic [1:0]  nb;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  mem [logic [15:0]];
  int          checks = 0;
  int          errors = 0;
  int          done_cnt = 0;
  int          stall_mode = 0;
  bit          junk_en = 1'b0;
  logic [7:0]  lfsr = 8'h5b;
  bit          toggle = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // Memory responder: latency pattern picked by stall_mode.
  always @(negedge clk) begin
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    toggle = ~toggle;
    if (fetch_req_o) begin
      case (stall_mode)
        0:       fetch_vld_i = 1'b1;
        1:       fetch_vld_i = toggle;
        default: fetch_vld_i = lfsr[0] & lfsr[2];
      endcase
      fetch_data_i = fetch_vld_i ? rd(fetch_addr_o) : 8'hcc;
    end else begin
      fetch_vld_i  = junk_en;
      fetch_data_i = 8'hee;
    end
  end

  // Monitor: compare each result strobe against the scoreboard.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", {16'h0, ea_o}, 32'h0);
      end else begin
        exp_t e;
        string tag;
        e = exp_q.pop_front();
        case (e.mode)
          2'b00:   tag = "R2";
          2'b01:   tag = "R3";
          2'b10:   tag = "R4";
          default: tag = "R5";
        endcase
        chk(ea_o == e.ea, {tag, " ea"}, {16'h0, ea_o}, {16'h0, e.ea});
        chk(nbytes_o == e.nb, {tag, " nbytes"}, {30'h0, nbytes_o}, {30'h0, e.nb});
        chk(pc_next_o == e.pc, "R6 pc_next", {16'h0, pc_next_o}, {16'h0, e.pc});
      end
    end
  end

  task automatic issue(input logic [1:0] m, input logic [15:0] pc, input logic [7:0] dp,
                       input logic [7:0] b0, input logic [7:0] b1);
    exp_t        e;
    logic [1:0]  n;
    logic [15:0] pa;
    n  = (m == 2'b01 || m == 2'b11) ? 2'd2 : 2'd1;
    pa = pc + 16'(n);
    mem[pc]         = b0;
    mem[pc + 16'd1] = b1;
    e.mode = m;
    e.nb   = n;
    e.pc   = pa;
    case (m)
      2'b00:   e.ea = {dp, b0};
      2'b01:   e.ea = {b0, b1};
      2'b10:   e.ea = pa + {{8{b0[7]}}, b0};
      default: e.ea = pa + {b0, b1};
    endcase
    exp_q.push_back(e);
    start_i = 1'b1; mode_i = m; pc_i = pc; dp_i = dp;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk(done_o == 1'b0 && fetch_req_o == 1'b0, "R1 strobes in reset", {30'h0, done_o, fetch_req_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", {31'h0, done_o}, 32'h0);
    chk(fetch_req_o == 1'b0, "R1 fetch_req after reset", {31'h0, fetch_req_o}, 32'h0);
    chk(ea_o == 16'h0 && pc_next_o == 16'h0 && nbytes_o == 2'd0, "R1 results after reset",
        {ea_o, pc_next_o}, 32'h0);

    // R7: stray valid strobes while idle have no effect
    junk_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0 && fetch_req_o == 1'b0, "R7 idle valid ignored", {30'h0, done_o, fetch_req_o}, 32'h0);

    // R2..R5 with immediate memory
    issue(2'b00, 16'h1200, 8'h34, 8'h56, 8'h00);
    chk(fetch_req_o == 1'b1, "R7 request after start", {31'h0, fetch_req_o}, 32'h1);
    drain();
    issue(2'b00, 16'h0040, 8'hff, 8'hff, 8'h00);   drain();
    issue(2'b01, 16'h3000, 8'h00, 8'hab, 8'hcd);   drain();
    issue(2'b01, 16'hffff, 8'h00, 8'h12, 8'h34);   drain();   // R6 fetch wrap
    issue(2'b10, 16'h2000, 8'h00, 8'h10, 8'h00);   drain();
    issue(2'b10, 16'h0000, 8'h00, 8'h80, 8'h00);   drain();   // R4 negative, wraps below 0
    issue(2'b11, 16'h8000, 8'h00, 8'h7f, 8'hf0);   drain();
    issue(2'b11, 16'hfff0, 8'h00, 8'h00, 8'h20);   drain();   // R5 sum wraps

    // Alternating and irregular latency
    junk_en = 1'b0;
    stall_mode = 1;
    issue(2'b11, 16'h4444, 8'h00, 8'hff, 8'hfe);   drain();
    issue(2'b00, 16'h5555, 8'h9a, 8'h01, 8'h00);   drain();
    stall_mode = 2;
    issue(2'b10, 16'h6000, 8'h00, 8'hfe, 8'h00);   drain();
    issue(2'b01, 16'h7000, 8'h00, 8'h00, 8'h01);   drain();

    // R9: start pulse while busy is ignored
    issue(2'b01, 16'h9000, 8'h00, 8'h11, 8'h22);
    if (fetch_req_o) begin
      start_i = 1'b1; mode_i = 2'b00; pc_i = 16'hdead; dp_i = 8'h77;
      @(negedge clk);
      start_i = 1'b0;
    end
    drain();
    d0 = done_cnt;
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 && fetch_req_o == 1'b0, "R9 no extra request", done_cnt, d0);

    // R10: new start in the result cycle
    stall_mode = 0;
    issue(2'b10, 16'ha000, 8'h00, 8'h05, 8'h00);
    while (!done_o) @(negedge clk);
    issue(2'b11, 16'hb000, 8'h00, 8'h01, 8'h00);
    chk(fetch_req_o == 1'b1, "R10 back-to-back accept", {31'h0, fetch_req_o}, 32'h1);
    drain();
    chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule